// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers requests from a set of interrupt lines and hands one winner at a time to a simple processor core as a line number (vector). It accepts a request into the presentation stage only on the cycle where the core strobes that one instruction has retired and the next has not yet started. This means an instruction never sees a condition change partway through. Priority is fixed: a lower line number beats a higher one. A software-written mask can silence ordinary lines. The lowest lines cannot be silenced: line 0 is the non-maskable line, and the few lines above it carry the core's internal fault traps.

The controller remembers which handlers are running. When the core acknowledges a vector, that line enters the in-service set. The current service level is the most urgent line in that set. A new request is offered only if it outranks the current level, so an urgent line preempts a less urgent handler. Each end-of-handler strobe retires the most urgent running handler. The level then drops one step back towards the interrupted handler, and finally back to the base program.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_valid` is low, no line is pending or in service, and every mask bit is 1. A mask bit of 1 disables its line, so after reset only the unmaskable lines can be presented.
- R2: A request line that is high at a rising clock edge makes that line pending. The line stays pending after the request drops, until that vector is acknowledged.
- R3: `irq_valid` rises only on the clock edge at which `insn_boundary` is high. Without that strobe, pending lines are never presented. While `irq_valid` is high and `irq_ack` is low, `irq_vec` holds its value, even if new requests arrive or the strobe repeats.
- R4: Among pending, enabled lines, the lowest-numbered line wins. `irq_vec` carries its line number as a binary value.
- R5: Writing `mask_wdata` with `mask_we` high loads the mask. Bit i = 1 blocks line i for every i at or above `UNMASKABLE`. A blocked line stays pending and is presented at a later strobe once its mask bit is cleared.
- R6: Lines 0 (non-maskable) to `UNMASKABLE`-1 (trap lines, 0 to 2 by default) are presented whatever their mask bits hold.
- R7: A line is presented only if its number is strictly less than the current service level. The current service level is the lowest-numbered in-service line, or all lines are allowed when nothing is in service.
- R8: `irq_ack` while `irq_valid` is high does three things on that edge. It puts the presented line in service, clears its pending bit, and drops `irq_valid`.
- R9: `handler_done` takes the lowest-numbered line out of service. The level then falls back to the next in-service line, or to the base program when none is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lines | input | NUM_LINES | Level-sensitive interrupt requests, line 0 most urgent |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | NUM_LINES | New mask value, 1 disables a maskable line |
| insn_boundary | input | 1 | Strobe from the core between two instructions |
| irq_ack | input | 1 | Core accepts the presented vector |
| handler_done | input | 1 | Core finished the most urgent running handler |
| irq_valid | output | 1 | A vector is being presented |
| irq_vec | output | VEC_W | Number of the presented line |

## Verification
The assertions assume the core follows three rules. It raises `irq_ack` only while `irq_valid` is high. It raises `handler_done` only when some handler is running. It never raises both strobes in the same cycle. The stimulus keeps to these rules by construction: it builds every scenario from a few tasks that acknowledge only after seeing `irq_valid` and retire handlers only after acknowledging them. Every request is a one-cycle pulse, so a line never re-enters pending while it is being serviced. A fresh reset separates the sweeps over single lines, line pairs, mask settings and nesting pairs.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic {
    PH_IDLE    = 1'b0,
    PH_PRESENT = 1'b1
  } nic_phase_e;
endpackage

// File: rtl/nic_prio_enc.sv
module nic_prio_enc #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_in,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_in[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int N          = 32,
  parameter int UNMASKABLE = 3,
  parameter int IW         = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_wdata,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend_raw,
  output logic [N-1:0]  pend_ok
);
  logic [N-1:0] pend_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] block;
  logic [N-1:0] clr_vec;

  for (genvar g = 0; g < N; g++) begin : g_line
    if (g < UNMASKABLE) begin : g_fixed
      assign block[g] = 1'b0;
    end else begin : g_soft
      assign block[g] = mask_q[g];
    end
    assign clr_vec[g] = clr_en && (clr_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= (pend_q | req) & ~clr_vec;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign pend_raw = pend_q;
  assign pend_ok  = pend_q & ~block;

  p_ack_clears_pend_r8: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !pend_q[$past(clr_idx)]);

  p_pend_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '0) && !clr_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          done_en,
  output logic [IW:0]   level
);
  logic [N-1:0]  isr_q;
  logic          top_found;
  logic [IW-1:0] top_idx;
  logic [N-1:0]  set_vec;
  logic [N-1:0]  drop_vec;

  nic_prio_enc #(.N(N), .IW(IW)) u_top (
    .vec_in(isr_q),
    .found (top_found),
    .idx   (top_idx)
  );

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign set_vec[g]  = set_en && (set_idx == IW'(g));
    assign drop_vec[g] = done_en && top_found && (top_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= (isr_q & ~drop_vec) | set_vec;
  end

  assign level = top_found ? {1'b0, top_idx} : (IW + 1)'(N);

  p_ack_enters_service_r8: assert property (@(posedge clk) disable iff (rst)
    set_en |=> isr_q[$past(set_idx)]);

  p_done_unwinds_r9: assert property (@(posedge clk) disable iff (rst)
    done_en && !set_en && (isr_q != '0) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1) && (level > $past(level)));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_LINES  = 32,
  parameter int UNMASKABLE = 3,
  localparam int VEC_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_lines,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic                 insn_boundary,
  input  logic                 irq_ack,
  input  logic                 handler_done,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vec
);
  import nic_pkg::*;

  nic_phase_e           phase_q;
  logic [VEC_W-1:0]     vec_q;
  logic [NUM_LINES-1:0] pend_raw;
  logic [NUM_LINES-1:0] pend_ok;
  logic                 cand_found;
  logic [VEC_W-1:0]     cand_idx;
  logic [VEC_W:0]       level;
  logic                 take;
  logic                 accept;

  assign accept = irq_ack && (phase_q == PH_PRESENT);

  nic_pending #(.N(NUM_LINES), .UNMASKABLE(UNMASKABLE), .IW(VEC_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .req       (req_lines),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .clr_en    (accept),
    .clr_idx   (vec_q),
    .pend_raw  (pend_raw),
    .pend_ok   (pend_ok)
  );

  nic_prio_enc #(.N(NUM_LINES), .IW(VEC_W)) u_pick (
    .vec_in(pend_ok),
    .found (cand_found),
    .idx   (cand_idx)
  );

  nic_inservice #(.N(NUM_LINES), .IW(VEC_W)) u_isr (
    .clk    (clk),
    .rst    (rst),
    .set_en (accept),
    .set_idx(vec_q),
    .done_en(handler_done),
    .level  (level)
  );

  assign take = insn_boundary && (phase_q == PH_IDLE) && cand_found &&
                ({1'b0, cand_idx} < level);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      vec_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (take) begin
          phase_q <= PH_PRESENT;
          vec_q   <= cand_idx;
        end
        PH_PRESENT: if (irq_ack) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign irq_valid = (phase_q == PH_PRESENT);
  assign irq_vec   = vec_q;

  p_only_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(insn_boundary));

  p_vec_held_r3: assert property (@(posedge clk) disable iff (rst)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec));

  p_outranks_level_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> ({1'b0, irq_vec} < level));

  p_nmi_wins_r6: assert property (@(posedge clk) disable iff (rst)
    pend_raw[0] && insn_boundary && !irq_valid && (level == (VEC_W + 1)'(NUM_LINES))
      |=> irq_valid && (irq_vec == '0));

  p_ack_drops_valid_r8: assert property (@(posedge clk) disable iff (rst)
    irq_valid && irq_ack |=> !irq_valid);
endmodule

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
  localparam int N  = 32;
  localparam int UM = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_lines = '0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         insn_boundary = 1'b0;
  logic         irq_ack = 1'b0;
  logic         handler_done = 1'b0;
  logic         irq_valid;
  logic [4:0]   irq_vec;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  nest_irq_ctrl #(.NUM_LINES(N), .UNMASKABLE(UM)) i_nest_irq_ctrl (
    .clk(clk), .rst(rst), .req_lines(req_lines), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .insn_boundary(insn_boundary), .irq_ack(irq_ack),
    .handler_done(handler_done), .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_lines = '0; mask_we = 1'b0; insn_boundary = 1'b0;
    irq_ack = 1'b0; handler_done = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic set_mask(input logic [N-1:0] m);
    mask_we = 1'b1; mask_wdata = m; step(); mask_we = 1'b0;
  endtask

  task automatic pulse_req(input logic [N-1:0] r);
    req_lines = r; step(); req_lines = '0;
  endtask

  task automatic boundary();
    insn_boundary = 1'b1; step(); insn_boundary = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  task automatic hdone();
    handler_done = 1'b1; step(); handler_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step();
    do_reset();
    // R1: reset state, mask all ones
    chk("R1 valid after reset", irq_valid, 0);
    pulse_req(N'(1) << 10);
    boundary();
    chk("R1 maskable line blocked after reset", irq_valid, 0);

    // R5/R6: sweep each line under full mask
    for (int k = 0; k < N; k++) begin
      do_reset();
      pulse_req(N'(1) << k);
      boundary();
      chk($sformatf("R6 R5 line %0d under full mask", k), irq_valid, (k < UM) ? 1 : 0);
      if (k < UM) chk("R6 vector", irq_vec, k);
    end

    // R2/R4/R8: single line sweep
    for (int k = 0; k < N; k++) begin
      do_reset();
      set_mask('0);
      pulse_req(N'(1) << k);
      boundary();
      chk($sformatf("R2 line %0d presented", k), irq_valid, 1);
      chk("R4 single vector", irq_vec, k);
      ack();
      chk("R8 valid drops on ack", irq_valid, 0);
      hdone();
      boundary();
      chk("R8 pending cleared by ack", irq_valid, 0);
    end

    // R4: pair sweep
    for (int a = 0; a < N; a++) begin
      int b;
      b = (a * 7 + 3) % N;
      if (b == a) continue;
      do_reset();
      set_mask('0);
      pulse_req((N'(1) << a) | (N'(1) << b));
      boundary();
      chk("R4 pair valid", irq_valid, 1);
      chk($sformatf("R4 pair %0d,%0d", a, b), irq_vec, (a < b) ? a : b);
      ack(); hdone();
      boundary();
      chk("R4 loser follows", irq_vec, (a < b) ? b : a);
    end

    // R7: nesting sweep
    for (int a = 0; a < N; a++) begin
      int b;
      b = (a * 11 + 5) % N;
      if (b == a) continue;
      do_reset();
      set_mask('0);
      pulse_req(N'(1) << a);
      boundary();
      ack();
      pulse_req(N'(1) << b);
      boundary();
      chk($sformatf("R7 line %0d over level %0d", b, a), irq_valid, (b < a) ? 1 : 0);
      if (b < a) begin
        chk("R7 preempting vector", irq_vec, b);
        ack(); hdone();
      end
      hdone();
      boundary();
      if (b > a) chk("R9 deferred line after return", irq_vec, b);
      else       chk("R9 nothing left", irq_valid, 0);
    end

    // R3: no boundary, no presentation; vector frozen while presented
    do_reset();
    set_mask('0);
    pulse_req(N'(1) << 9);
    step(); step(); step();
    chk("R3 no strobe no valid", irq_valid, 0);
    boundary();
    chk("R3 strobe presents", irq_vec, 9);
    pulse_req(N'(1) << 4);
    boundary();
    chk("R3 vector held", irq_vec, 9);
    chk("R3 valid held", irq_valid, 1);

    // R9: level-by-level fallback
    do_reset();
    set_mask('0);
    pulse_req(N'(1) << 5);  boundary(); ack();
    pulse_req(N'(1) << 2);  boundary();
    chk("R7 line 2 preempts 5", irq_vec, 2);
    ack();
    pulse_req(N'(1) << 4);  boundary();
    chk("R7 line 4 waits under 2", irq_valid, 0);
    hdone(); boundary();
    chk("R9 line 4 after return to 5", irq_vec, 4);
    ack(); hdone();
    pulse_req(N'(1) << 7);  boundary();
    chk("R9 line 7 still blocked by 5", irq_valid, 0);
    hdone(); boundary();
    chk("R9 line 7 at base level", irq_vec, 7);

    // R5: masked line held, presented after unmask
    do_reset();
    set_mask(N'(1) << 20);
    pulse_req(N'(1) << 20);
    boundary();
    chk("R5 masked line not presented", irq_valid, 0);
    set_mask('0);
    boundary();
    chk("R5 presented after unmask", irq_vec, 20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule